// File: doc/BRIEF.md
# Keyed Reset Watchdog Timer

This block is a watchdog timer that counts down on a slow 32.768 kHz tick and, if software lets it run out, drives a reset pulse to the rest of the system. The timeout is a 32-bit reload value held in two 16-bit registers. A control register holds the run bit, a stored mode bit and the reset enable. A lock register guards all three: the block leaves reset locked, and only the 16-bit key 0xE551 opens it. Any other value written there closes it again, so a stray write cannot move the timeout or stop the count.

The slow tick reaches the block as a level on `tick_in`. The block passes it through a two-flop synchronizer and turns each rising edge into a one-cycle tick in the system clock domain. Counting is controlled by a three-state machine:
- **IDLE**: stopped, with the run bit reading 0.
- **COUNT**: counting down, with the run bit reading 1.
- **FIRE**: the reset pulse is being driven.

The transitions are:
- **arm** (IDLE to COUNT): a control write that sets run. It reloads the counter.
- **halt** (COUNT to IDLE): a control write that clears run.
- **lapse** (COUNT to IDLE): expiry while the reset enable is clear.
- **expire** (COUNT to FIRE): expiry while the reset enable is set.
- **release** (FIRE to IDLE): the end of the pulse.

A typical use is a restart path. Software unlocks the block, loads a value such as 1638 (50 ms at 32.768 kHz), sets run together with the reset enable, and relocks it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the block is locked (lock register at 0x20 reads 1 in bit 0), the load and control registers read 0, and `wdog_rst` is low.
- R2: While locked, writes to the load-low, load-high and control registers are ignored, and reads still return their current contents.
- R3: Writing exactly 0xE551 to the lock register (0x20) unlocks the block, after which the lock register reads 0.
- R4: Writing any other value to the lock register locks the block (reads 1).
- R5: The register map is as follows:
  - load-low at 0x00, bits 15:0.
  - load-high at 0x04, bits 15:0. The two halves form a 32-bit load value {high, low}.
  - control at 0x08: run in bit 1, mode in bit 2, reset enable in bit 3. Its other bits read 0.
  - Every unmapped address reads 0.
- R6: An unlocked control write with bit 1 set, while the block is idle, reloads the counter from {high, low} and sets run. The same write while the block is already counting does not reload.
- R7: A rising edge of `tick_in` sampled at clock edge k decrements the counter at edge k+2, once per edge.
- R8: The tick that finds the counter at 1 or 0 is the expiry. It is the N-th tick after arming with load N, or the first tick when N is 0. On expiry run clears. If the reset enable is set, `wdog_rst` goes high after that edge for exactly RST_CYCLES (default 4) clocks.
- R9: On expiry with the reset enable clear, run clears and no reset pulse is produced.
- R10: An unlocked control write with bit 1 clear stops counting. No expiry follows, however many ticks arrive.
- R11: While the pulse is driven, a control write setting run does not arm the block. Once the pulse ends the block is idle and can be armed again.
- R12: The mode bit is stored and read back but does not change counting or expiry.
- R13: A load of 1638 (50 ms at 32.768 kHz) expires on exactly the 1638th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Slow tick level; each rising edge is one count |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| wdog_rst | output | 1 | Reset pulse on expiry |

## Verification
On every cycle, the assertions check the following:
- the key and relock rules;
- that locked writes leave the load value unchanged;
- that a tick is a single-cycle pulse;
- that an arm loads the combined load value;
- that each tick steps the counter down by one;
- that an expiry with reset enabled raises the pulse;
- that FIRE never leads straight back into counting.

The exact cycle on which expiry lands, the pulse width, and the absence of a pulse after a halt or a lapse can only be shown by the bench's scenarios. The bench compares its reference model's readback and reset output with the design on every clock. This covers the 1638-tick timeout and a load with a nonzero high half.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } kw_state_e;

    localparam logic [5:0] A_LOAD_LO = 6'h00;
    localparam logic [5:0] A_LOAD_HI = 6'h04;
    localparam logic [5:0] A_CTRL    = 6'h08;
    localparam logic [5:0] A_LOCK    = 6'h20;

    localparam logic [15:0] UNLOCK_KEY = 16'hE551;

    localparam int B_RUN   = 1;
    localparam int B_MODE  = 2;
    localparam int B_RSTEN = 3;

endpackage

// File: rtl/kw_tick_edge.sv
module kw_tick_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= tick_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign tick_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R7: a detected edge lasts exactly one system clock
    a_r7_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/kw_cfg_regs.sv
module kw_cfg_regs
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run_now,
    output logic [CNT_W-1:0]  load_val,
    output logic              rsten_q,
    output logic              ctrl_wr,
    output logic              ctrl_run,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lo_q, hi_q;
    logic              mode_q;
    logic              locked_q;
    logic              hit_lo, hit_hi, hit_ctrl, hit_lock;
    logic              cfg_ok;

    assign hit_lo   = (addr == ADDR_W'(A_LOAD_LO));
    assign hit_hi   = (addr == ADDR_W'(A_LOAD_HI));
    assign hit_ctrl = (addr == ADDR_W'(A_CTRL));
    assign hit_lock = (addr == ADDR_W'(A_LOCK));
    assign cfg_ok   = wr && !locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
        end else if (wr && hit_lock) begin
            locked_q <= (wdata != DATA_W'(UNLOCK_KEY));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            mode_q  <= 1'b0;
            rsten_q <= 1'b0;
        end else if (cfg_ok) begin
            if (hit_lo) lo_q <= wdata;
            if (hit_hi) hi_q <= wdata;
            if (hit_ctrl) begin
                mode_q  <= wdata[B_MODE];
                rsten_q <= wdata[B_RSTEN];
            end
        end
    end

    assign load_val = {hi_q, lo_q};
    assign ctrl_wr  = cfg_ok && hit_ctrl;
    assign ctrl_run = wdata[B_RUN];

    always_comb begin
        rdata = '0;
        if (hit_lo) begin
            rdata = lo_q;
        end else if (hit_hi) begin
            rdata = hi_q;
        end else if (hit_ctrl) begin
            rdata[B_RUN]   = run_now;
            rdata[B_MODE]  = mode_q;
            rdata[B_RSTEN] = rsten_q;
        end else if (hit_lock) begin
            rdata[0] = locked_q;
        end
    end

    // R2: locked writes leave the load halves unchanged
    a_r2_locked_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr && hit_lo) |=> $stable(lo_q));
    a_r2_locked_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr && hit_hi) |=> $stable(hi_q));
    // R3: the key opens the block
    a_r3_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_lock && wdata == DATA_W'(UNLOCK_KEY)) |=> !locked_q);
    // R4: any other value closes it
    a_r4_stray_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_lock && wdata != DATA_W'(UNLOCK_KEY)) |=> locked_q);

endmodule

// File: rtl/kw_count_fsm.sv
module kw_count_fsm
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 4,
    localparam int FIRE_W    = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             ctrl_run,
    input  logic             rsten,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             rst_out
);
    kw_state_e          st_q, st_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIRE_W-1:0]  fire_q;
    logic               arm, halt, cnt_low;

    assign arm     = ctrl_wr && ctrl_run;
    assign halt    = ctrl_wr && !ctrl_run;
    assign cnt_low = (cnt_q[CNT_W-1:1] == '0);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:  if (arm) st_nxt = ST_COUNT;
            ST_COUNT: begin
                if (halt)                 st_nxt = ST_IDLE;
                else if (tick && cnt_low) st_nxt = rsten ? ST_FIRE : ST_IDLE;
            end
            ST_FIRE:  if (fire_q == '0) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_IDLE && arm) begin
            cnt_q <= load_val;
        end else if (st_q == ST_COUNT && !halt && tick) begin
            cnt_q <= cnt_low ? '0 : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= '0;
        end else if (st_q != ST_FIRE && st_nxt == ST_FIRE) begin
            fire_q <= FIRE_W'(RST_CYCLES - 1);
        end else if (st_q == ST_FIRE && fire_q != '0) begin
            fire_q <= fire_q - 1'b1;
        end
    end

    always_comb begin
        running = (st_q == ST_COUNT);
        rst_out = (st_q == ST_FIRE);
    end

    // R6: arming loads the combined value
    a_r6_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && arm) |=> (st_q == ST_COUNT && cnt_q == $past(load_val)));
    // R7: each tick steps the counter down by one
    a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && tick && !halt && !cnt_low) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R8: expiry with reset enabled raises the pulse
    a_r8_expire_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && tick && !halt && cnt_low && rsten) |=> rst_out);
    // R11: the pulse is never cut short into counting
    a_r11_fire_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRE) |=> (st_q != ST_COUNT));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst
);
    localparam int CNT_W = 2 * DATA_W;

    logic             tick;
    logic [CNT_W-1:0] load_val;
    logic             rsten, ctrl_wr, ctrl_run, running;

    kw_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .tick_pulse (tick)
    );

    kw_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .run_now  (running),
        .load_val (load_val),
        .rsten_q  (rsten),
        .ctrl_wr  (ctrl_wr),
        .ctrl_run (ctrl_run),
        .rdata    (bus_rdata)
    );

    kw_count_fsm #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl_wr  (ctrl_wr),
        .ctrl_run (ctrl_run),
        .rsten    (rsten),
        .load_val (load_val),
        .running  (running),
        .rst_out  (wdog_rst)
    );

endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        wdog_rst;

    keyed_wdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdog_rst(wdog_rst)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  failures = 0;
    bit  cmp_en = 0;
    bit  rst_seen = 0;
    bit  done = 0;
    int  cyc = 0;

    // behavioural reference model
    bit      m_locked = 1, m_run = 0, m_mode = 0, m_rsten = 0;
    int      m_lo = 0, m_hi = 0, m_fire = 0;
    longint  m_cnt = 0;
    bit      m_sync[$] = '{0, 0, 0};

    function automatic int m_read(logic [5:0] a);
        case (a)
            6'h00:   return m_lo;
            6'h04:   return m_hi;
            6'h08:   return (int'(m_rsten) << 3) | (int'(m_mode) << 2) | (int'(m_run) << 1);
            6'h20:   return int'(m_locked);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_locked = 1; m_run = 0; m_mode = 0; m_rsten = 0;
            m_lo = 0; m_hi = 0; m_fire = 0; m_cnt = 0;
            m_sync = '{0, 0, 0};
        end else begin
            bit tp, cw;
            tp = m_sync[1] && !m_sync[2];
            cw = bus_wr && !m_locked && bus_addr == 6'h08;
            if (m_fire > 0) m_fire--;
            else if (m_run) begin
                if (cw && !bus_wdata[1]) m_run = 0;
                else if (tp) begin
                    if (m_cnt <= 1) begin
                        m_cnt = 0; m_run = 0;
                        if (m_rsten) m_fire = RSTC;
                    end else m_cnt--;
                end
            end else if (cw && bus_wdata[1]) begin
                m_run = 1;
                m_cnt = (longint'(m_hi) << 16) | longint'(m_lo);
            end
            if (bus_wr) begin
                if (bus_addr == 6'h20) m_locked = (bus_wdata != 16'hE551);
                else if (!m_locked) begin
                    if (bus_addr == 6'h00) m_lo = int'(bus_wdata);
                    if (bus_addr == 6'h04) m_hi = int'(bus_wdata);
                    if (bus_addr == 6'h08) begin
                        m_mode = bus_wdata[2]; m_rsten = bus_wdata[3];
                    end
                end
            end
            void'(m_sync.pop_back());
            m_sync.push_front(tick_in);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R7 timing, R8 pulse width)
    always @(negedge clk) begin
        if (wdog_rst) rst_seen = 1;
        if (cmp_en && !done) begin
            chk("R8 model rst", int'(wdog_rst), int'(m_fire > 0));
            chk("R7 model rdata", int'(bus_rdata), m_read(bus_addr));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, int exp);
        bus_addr = a;
        @(negedge clk);
        chk(tag, int'(bus_rdata), exp);
        step(1);
    endtask

    task automatic tick_n(int n);
        repeat (n) begin
            tick_in = 1; step(2);
            tick_in = 0; step(2);
        end
    endtask

    task automatic fast_ticks(int n);
        repeat (n) begin
            tick_in = 1; step(1);
            tick_in = 0; step(1);
        end
        step(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        cmp_en = 1;
        // R1: reset state
        chk("R1 rst low", int'(wdog_rst), 0);
        rd_chk("R1 lock reads 1", 6'h20, 1);
        rd_chk("R1 ctrl 0", 6'h08, 0);
        rd_chk("R1 lo 0", 6'h00, 0);
        // R2: locked writes ignored
        wr(6'h00, 16'h1234);
        wr(6'h08, 16'h000A);
        rd_chk("R2 lo unchanged", 6'h00, 0);
        rd_chk("R2 ctrl unchanged", 6'h08, 0);
        // R3: key unlocks
        wr(6'h20, 16'hE551);
        rd_chk("R3 lock reads 0", 6'h20, 0);
        // R5: map
        wr(6'h00, 16'h0005);
        wr(6'h04, 16'h0000);
        wr(6'h0C, 16'hFFFF);
        rd_chk("R5 lo readback", 6'h00, 5);
        rd_chk("R5 unmapped 0", 6'h0C, 0);
        // R4: wrong key relocks
        wr(6'h20, 16'hE550);
        rd_chk("R4 lock reads 1", 6'h20, 1);
        wr(6'h00, 16'h0007);
        rd_chk("R2 lo kept while relocked", 6'h00, 5);
        wr(6'h20, 16'hE551);
        // R6/R7/R8: arm with load 5
        wr(6'h08, 16'h000A);
        rd_chk("R6 run set", 6'h08, 16'h000A);
        tick_n(4);
        chk("R7 no expiry before 5th tick", int'(rst_seen), 0);
        wr(6'h08, 16'h000A);     // already counting: no reload
        tick_n(1);
        chk("R6 no reload, R8 expiry on 5th tick", int'(wdog_rst), 1);
        step(8);
        chk("R8 pulse over", int'(wdog_rst), 0);
        rd_chk("R8 run cleared", 6'h08, 16'h0008);
        // R8/R11: load 0, run write during pulse
        wr(6'h00, 16'h0000);
        wr(6'h08, 16'h000A);
        tick_n(1);
        chk("R8 load 0 expires on first tick", int'(wdog_rst), 1);
        wr(6'h08, 16'h000A);
        step(8);
        rd_chk("R11 run write during pulse ignored", 6'h08, 16'h0008);
        wr(6'h08, 16'h000A);
        rd_chk("R11 re-arm after pulse", 6'h08, 16'h000A);
        wr(6'h08, 16'h0008);
        // R9: expiry without reset enable
        wr(6'h00, 16'h0002);
        wr(6'h08, 16'h0002);
        rst_seen = 0;
        tick_n(2);
        step(6);
        chk("R9 no pulse", int'(rst_seen), 0);
        rd_chk("R9 run cleared", 6'h08, 0);
        // R10: halt
        wr(6'h00, 16'h0003);
        wr(6'h08, 16'h000A);
        tick_n(2);
        wr(6'h08, 16'h0008);
        rst_seen = 0;
        tick_n(3);
        step(6);
        chk("R10 halted no pulse", int'(rst_seen), 0);
        rd_chk("R10 run reads 0", 6'h08, 16'h0008);
        // R12: mode bit stored, no effect
        wr(6'h00, 16'h0002);
        wr(6'h08, 16'h000E);
        rd_chk("R12 mode readback", 6'h08, 16'h000E);
        rst_seen = 0;
        tick_n(1);
        chk("R12 no early expiry", int'(rst_seen), 0);
        tick_n(1);
        chk("R12 expiry on 2nd tick", int'(wdog_rst), 1);
        step(8);
        // R13: 50 ms load
        wr(6'h00, 16'd1638);
        wr(6'h08, 16'h000A);
        rst_seen = 0;
        fast_ticks(1637);
        chk("R13 no pulse after 1637 ticks", int'(rst_seen), 0);
        tick_n(1);
        chk("R13 pulse on tick 1638", int'(wdog_rst), 1);
        step(8);
        // R5: high half participates
        wr(6'h04, 16'h0001);
        wr(6'h00, 16'h0001);
        rd_chk("R5 hi readback", 6'h04, 1);
        wr(6'h08, 16'h000A);
        rst_seen = 0;
        fast_ticks(65536);
        chk("R5 no pulse after 65536 ticks", int'(rst_seen), 0);
        tick_n(1);
        chk("R5 pulse on tick 65537", int'(wdog_rst), 1);
        step(8);
        wr(6'h20, 16'h0000);
        wr(6'h04, 16'h0009);
        rd_chk("R2 hi kept while locked", 6'h04, 1);
        step(2);
        finish_run();
    end
endmodule